// File: doc/BRIEF.md
# Edge-Triggered Interrupt Collector with Posted Message Output

This block gathers a set of level-sensitive interrupt lines (eleven by default) and turns each fresh rising edge into a posted memory-write message aimed at the processor. It records the present level of every line. Each new edge is latched as a sticky pending bit. For sources that are enabled, a single-beat write request is raised on a valid/ready port, and both its address and its data are taken from one of two programmable target words.

Software uses a small register port with one-cycle write and combinational read. The map holds a live level view, an enable mask, the pending bits, a per-source selector that picks between the two target words, the two target words, and two read-only views. These views show the enabled sources that are currently asserted, split by selector value. By default the sources are assigned as follows: bits 0 to 5 carry the six bus interrupt lines, bit 6 an external request, bit 7 a recoverable bus error, bit 8 the keyboard/mouse port, bit 9 nothing, and bit 10 the serial port.

Each target word has at most one waiting message. When the outbound port stalls, further edges routed to a target that already has a message waiting are merged into it. The pending bits still record every one of those edges.

Top module: `irq_msg_ctrl`

## Requirements
- R1: The level register (address 0) shows, one clock after sampling, the value of each input line: 1 while the line is high, 0 while it is low.
- R2: A pending bit (address 2) is set only in the cycle a line is seen high while its level bit is still 0. A line held high does not set the bit again.
- R3: A read of address 2 returns the pending bits and then clears them. An edge in the same cycle stays pending.
- R4: Any write to address 2 clears the pending bits, whatever the write data.
- R5: A new edge whose enable bit (address 1) is 1 produces one outbound message. An edge whose enable bit is 0 produces no message but is still recorded as pending.
- R6: The selector bit of the source (address 3) chooses the target word: 0 uses target word A (address 4), 1 uses target word B (address 5).
- R7: The message address is the chosen target word with its low five bits forced to zero. The message data is the low five bits of that word, zero-extended.
- R8: Address 6 reads level AND enable AND NOT selector. Address 7 reads level AND enable AND selector.
- R9: Writes to addresses 0, 6 and 7 change no state.
- R10: After reset both target words read 0xFFFB0003. Level, enable, pending and selector read 0, and no message is valid.
- R11: Each target word keeps at most one waiting message, and a message for word A is issued before one for word B. Edges routed to a word that already has a message waiting are merged into it.
- R12: While a message is valid and not accepted, valid stays high and the address and data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NSRC | Interrupt lines, level sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers the clear-on-read side effect) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_addr | output | 32 | Outbound write address |
| msg_data | output | 32 | Outbound write data |

## Verification
The bench aims at five hazards: a line held high that sends messages again and again, a pending clear that drops an edge arriving in the same cycle, and a selector that is ignored or inverted so the message goes to the wrong word. The fourth is a mix-up of the address and data halves of the target word, which shows up as unaligned addresses or data wider than five bits. The fifth is a stalled outbound port. There the bench fires two words' worth of edges at once and then adds two more edges for a word that already has a message waiting. A design that queued too much would emit extra messages, one that queued too little would lose one, and one that got the priority wrong would issue them out of order. All of these show up as a mismatch against the expected message stream.

// File: rtl/irqmc_pkg.sv
package irqmc_pkg;
  localparam int DW = 32;
  localparam int OFS_BITS = 5;
  localparam logic [DW-1:0] TGT_RESET = 32'hFFFB_0003;

  typedef enum logic [2:0] {
    RA_LEVEL = 3'd0,
    RA_MASK  = 3'd1,
    RA_PEND  = 3'd2,
    RA_ROUTE = 3'd3,
    RA_TGTA  = 3'd4,
    RA_TGTB  = 3'd5,
    RA_VIEWA = 3'd6,
    RA_VIEWB = 3'd7
  } reg_addr_e;

  // Outbound address: target word aligned down to 32 bytes
  function automatic logic [DW-1:0] msg_addr_f(input logic [DW-1:0] t);
    return t & ~((DW'(1) << OFS_BITS) - DW'(1));
  endfunction

  // Outbound data: offset field of the target word
  function automatic logic [DW-1:0] msg_data_f(input logic [DW-1:0] t);
    return t & ((DW'(1) << OFS_BITS) - DW'(1));
  endfunction
endpackage

// File: rtl/irqmc_level.sv
module irqmc_level #(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  output logic [NSRC-1:0] lvl_q,
  output logic [NSRC-1:0] edge_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= irq_in;
  end

  // New edge: line high while its recorded level is still low
  assign edge_o = irq_in & ~lvl_q;
endmodule

// File: rtl/irqmc_regs.sv
module irqmc_regs
  import irqmc_pkg::*;
#(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] lvl_i,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] route_q,
  output logic [NSRC-1:0] pend_q,
  output logic [DW-1:0]   tgta_q,
  output logic [DW-1:0]   tgtb_q
);
  localparam int PADW = DW - NSRC;

  logic pend_clr;
  assign pend_clr = (reg_wr || reg_rd) && (reg_addr == RA_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      route_q <= '0;
      pend_q  <= '0;
      tgta_q  <= TGT_RESET;
      tgtb_q  <= TGT_RESET;
    end else begin
      pend_q <= (pend_clr ? '0 : pend_q) | edge_i;
      if (reg_wr) begin
        case (reg_addr)
          RA_MASK:  mask_q  <= reg_wdata[NSRC-1:0];
          RA_ROUTE: route_q <= reg_wdata[NSRC-1:0];
          RA_TGTA:  tgta_q  <= reg_wdata;
          RA_TGTB:  tgtb_q  <= reg_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_LEVEL: reg_rdata = {{PADW{1'b0}}, lvl_i};
      RA_MASK:  reg_rdata = {{PADW{1'b0}}, mask_q};
      RA_PEND:  reg_rdata = {{PADW{1'b0}}, pend_q};
      RA_ROUTE: reg_rdata = {{PADW{1'b0}}, route_q};
      RA_TGTA:  reg_rdata = tgta_q;
      RA_TGTB:  reg_rdata = tgtb_q;
      RA_VIEWA: reg_rdata = {{PADW{1'b0}}, lvl_i & mask_q & ~route_q};
      default:  reg_rdata = {{PADW{1'b0}}, lvl_i & mask_q & route_q};
    endcase
  end
endmodule

// File: rtl/irqmc_msgq.sv
module irqmc_msgq
  import irqmc_pkg::*;
#(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] edge_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] route_i,
  input  logic [DW-1:0]   tgta_i,
  input  logic [DW-1:0]   tgtb_i,
  output logic [1:0]      hit_o,
  output logic [1:0]      wait_o,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [DW-1:0]   msg_addr,
  output logic [DW-1:0]   msg_data
);
  localparam int NTGT = 2;

  logic [DW-1:0]   tgt [NTGT];
  logic [NTGT-1:0] req_q, grant;
  logic            take;
  logic            sel;

  assign tgt[0] = tgta_i;
  assign tgt[1] = tgtb_i;

  // Enabled edges, split by selector bit
  for (genvar g = 0; g < NTGT; g++) begin : g_hit
    if (g == 0) begin : g_a
      assign hit_o[g] = |(edge_i & mask_i & ~route_i);
    end else begin : g_b
      assign hit_o[g] = |(edge_i & mask_i & route_i);
    end
  end

  assign take  = !msg_valid || msg_ready;
  assign sel   = !req_q[0];
  assign grant = take ? (req_q & (sel ? 2'b10 : 2'b01)) : 2'b00;
  assign wait_o = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      req_q <= (req_q & ~grant) | hit_o;
      if (take) begin
        msg_valid <= |req_q;
        if (|req_q) begin
          msg_addr <= msg_addr_f(tgt[sel]);
          msg_data <= msg_data_f(tgt[sel]);
        end
      end
    end
  end
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irqmc_pkg::*;
#(
  parameter int NSRC = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [2:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            msg_valid,
  input  logic            msg_ready,
  output logic [31:0]     msg_addr,
  output logic [31:0]     msg_data
);
  logic [NSRC-1:0] lvl_q, edge_w, mask_q, route_q, pend_q;
  logic [DW-1:0]   tgta_q, tgtb_q;
  logic [1:0]      hit_w, wait_w;

  irqmc_level #(.NSRC(NSRC)) u_level (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl_q(lvl_q), .edge_o(edge_w)
  );

  irqmc_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .edge_i(edge_w), .lvl_i(lvl_q),
    .mask_q(mask_q), .route_q(route_q), .pend_q(pend_q),
    .tgta_q(tgta_q), .tgtb_q(tgtb_q)
  );

  irqmc_msgq #(.NSRC(NSRC)) u_msgq (
    .clk(clk), .rst_n(rst_n),
    .edge_i(edge_w), .mask_i(mask_q), .route_i(route_q),
    .tgta_i(tgta_q), .tgtb_i(tgtb_q),
    .hit_o(hit_w), .wait_o(wait_w),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/irqmc_chk.sv
module irqmc_chk #(
  parameter int NSRC = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] irq_in,
  input logic [NSRC-1:0] lvl,
  input logic [NSRC-1:0] edge_w,
  input logic [NSRC-1:0] pend,
  input logic            reg_wr,
  input logic            reg_rd,
  input logic [2:0]      reg_addr,
  input logic            msg_valid,
  input logic            msg_ready,
  input logic [31:0]     msg_addr,
  input logic [31:0]     msg_data
);
  logic up_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= 1'b0;
    else        up_q <= 1'b1;
  end

  logic rd_pend, wr_pend;
  assign rd_pend = reg_rd && (reg_addr == 3'd2);
  assign wr_pend = reg_wr && (reg_addr == 3'd2);

  p_level_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> lvl == $past(irq_in));

  p_pend_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (pend & $past(edge_w)) == $past(edge_w));

  p_pend_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (pend & ~$past(pend) & ~$past(edge_w)) == '0);

  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(rd_pend)) |-> (pend & ~$past(edge_w)) == '0);

  p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && $past(wr_pend)) |-> (pend & ~$past(edge_w)) == '0);

  p_msg_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_addr[4:0] == 5'd0) && (msg_data[31:5] == 27'd0));

  p_msg_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_addr) && $stable(msg_data));
endmodule

bind irq_msg_ctrl irqmc_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .lvl(lvl_q), .edge_w(edge_w),
  .pend(pend_q), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/tb_irq_msg_ctrl.sv
module tb_irq_msg_ctrl;
  localparam int NSRC = 11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            msg_valid, msg_ready = 1'b1;
  logic [31:0]     msg_addr, msg_data;

  always #2 clk = ~clk;

  irq_msg_ctrl #(.NSRC(NSRC)) dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed { logic [31:0] a; logic [31:0] d; } msg_t;
  msg_t exp_q[$];
  logic [31:0] ta_m = 32'hFFFB_0003, tb_m = 32'hFFFB_0003;

  function automatic msg_t expect_of(input logic [31:0] t);
    msg_t m;
    m.a = {t[31:5], 5'b00000};
    m.d = {27'd0, t[4:0]};
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic set_irq(input logic [NSRC-1:0] v);
    @(posedge clk); #1;
    irq_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Scoreboard monitor: accepted messages against the expected stream; stall stability
  logic        stall_p = 1'b0;
  logic [31:0] addr_p, data_p;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_p) begin
        chk("R12 valid held", {31'd0, msg_valid}, 32'd1);
        chk("R12 addr held", msg_addr, addr_p);
        chk("R12 data held", msg_data, data_p);
      end
      if (msg_valid && msg_ready) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 unexpected message: actual %h/%h expected none", msg_addr, msg_data);
        end else begin
          msg_t e;
          e = exp_q.pop_front();
          chk("R7 message address", msg_addr, e.a);
          chk("R7 message data", msg_data, e.d);
        end
      end
      stall_p = msg_valid && !msg_ready;
      addr_p  = msg_addr;
      data_p  = msg_data;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 valid in reset", {31'd0, msg_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R10 reset values
    rd(3'd0, v); chk("R10 level", v, 32'd0);
    rd(3'd1, v); chk("R10 mask", v, 32'd0);
    rd(3'd2, v); chk("R10 pending", v, 32'd0);
    rd(3'd3, v); chk("R10 selector", v, 32'd0);
    rd(3'd4, v); chk("R10 target A", v, 32'hFFFB_0003);
    rd(3'd5, v); chk("R10 target B", v, 32'hFFFB_0003);

    // R1 R2 R3 R5: single edge, default target word A
    wr(3'd1, 32'h7FF);
    exp_q.push_back(expect_of(ta_m));
    set_irq(11'h008);
    rd(3'd0, v); chk("R1 level high", v, 32'h008);
    rd(3'd2, v); chk("R2 pending set", v, 32'h008);
    rd(3'd2, v); chk("R3 cleared by read", v, 32'd0);
    idle(5);
    rd(3'd2, v); chk("R2 held line no re-set", v, 32'd0);
    chk("R5 message issued", exp_q.size(), 32'd0);
    set_irq(11'h000);
    rd(3'd0, v); chk("R1 level low", v, 32'd0);

    // R6 R7: selector picks word B, then word A with new values
    ta_m = 32'h1234_5667; wr(3'd4, ta_m);
    tb_m = 32'hABCD_00FF; wr(3'd5, tb_m);
    wr(3'd3, 32'h020);
    exp_q.push_back(expect_of(tb_m));
    set_irq(11'h020);
    idle(5);
    chk("R6 word B message", exp_q.size(), 32'd0);
    exp_q.push_back(expect_of(ta_m));
    set_irq(11'h024);
    idle(5);
    chk("R6 word A message", exp_q.size(), 32'd0);
    rd(3'd2, v); chk("R2 two edges pending", v, 32'h024);
    set_irq(11'h000);

    // R5 disabled source; R4 write clears
    wr(3'd1, 32'h6FF);
    set_irq(11'h100);
    idle(6);
    rd(3'd2, v); chk("R5 masked edge pending", v, 32'h100);
    set_irq(11'h000);
    set_irq(11'h100);
    wr(3'd2, 32'h0);
    rd(3'd2, v); chk("R4 write zero clears", v, 32'd0);
    set_irq(11'h000);
    set_irq(11'h100);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R4 write ones clears", v, 32'd0);
    set_irq(11'h000);
    wr(3'd1, 32'h7FF);

    // R8 R9 R11: views and same-cycle ordering
    wr(3'd3, 32'h202);
    exp_q.push_back(expect_of(ta_m));
    exp_q.push_back(expect_of(tb_m));
    set_irq(11'h203);
    idle(6);
    chk("R11 A before B", exp_q.size(), 32'd0);
    rd(3'd6, v); chk("R8 view A", v, 32'h001);
    rd(3'd7, v); chk("R8 view B", v, 32'h202);
    wr(3'd1, 32'h7FD);
    rd(3'd7, v); chk("R8 view B masked", v, 32'h200);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0);
    rd(3'd0, v); chk("R9 level write ignored", v, 32'h203);
    rd(3'd6, v); chk("R9 view A write ignored", v, 32'h001);
    rd(3'd7, v); chk("R9 view B write ignored", v, 32'h200);
    wr(3'd1, 32'h7FF);
    set_irq(11'h000);
    rd(3'd2, v);

    // R11 R12: stalled port, merge of edges for a waiting word
    wr(3'd3, 32'h080);
    @(posedge clk); #1 msg_ready = 1'b0;
    exp_q.push_back(expect_of(ta_m));
    exp_q.push_back(expect_of(ta_m));
    exp_q.push_back(expect_of(tb_m));
    set_irq(11'h090);
    idle(3);
    set_irq(11'h0D0);
    idle(2);
    set_irq(11'h4D0);
    idle(5);
    chk("R12 valid while stalled", {31'd0, msg_valid}, 32'd1);
    rd(3'd2, v); chk("R11 edges kept pending", v, 32'h4D0);
    @(posedge clk); #1 msg_ready = 1'b1;
    idle(12);
    chk("R11 merged stream drained", exp_q.size(), 32'd0);
    set_irq(11'h000);
    idle(4);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule